// File: doc/BRIEF.md
# SDRAM Command Sequencer

This block sits on the controller side of a four-bank single-data-rate SDRAM and produces every command the memory sees. After reset it waits a start-up period, then precharges all banks, issues two auto refreshes and writes the mode register. Only after that does it accept work from a simple request port: one request names a bank, a row, a column and a direction. The sequencer opens the row, issues the column access with auto-precharge, and raises an acknowledge in the same cycle as that column command. Data capture and pad timing sit outside.

A refresh timer raises a pending flag once per refresh slot. The slot length is the 64 ms retention window divided by 4096 rows, then divided by the clock period. A pending refresh wins over a waiting request whenever the sequencer returns to idle. Every gap between commands is counted in clocks from parameters, so a speed grade is chosen by setting those parameters.

The state machine has six states. ST_POWERUP waits for the start-up time and then issues precharge-all, moving to ST_INIT_REF1. ST_INIT_REF1 issues a refresh and moves to ST_INIT_REF2. ST_INIT_REF2 issues a refresh and moves to ST_INIT_MODE. ST_INIT_MODE issues the mode write and moves to ST_IDLE. ST_IDLE issues a refresh and stays in ST_IDLE when one is pending. Otherwise it issues an activate and moves to ST_COLUMN when a request is valid. ST_COLUMN issues the read or write and returns to ST_IDLE. Every state holds with a NOP until the gap timer has expired.

Top module: `sdram_seq`

## Requirements
- R1: While reset is high the command pins show NOP, both DQM bits are 1 and req_ack is 0. The first command after reset comes no earlier than T_INIT clocks after the first clock edge with reset low.
- R2: The start-up sequence is precharge with A10=1, then refresh, then refresh, then mode write. The gaps are exactly T_RP, T_RFC and T_RFC clocks.
- R3: The mode write drives BA=0 and A[6:4]=CAS_LAT. It also drives A[3]=0 (sequential) and A[2:0]=000 (burst of one), with every other A bit 0. DQM stays 11 until the mode write and is 00 from that cycle on.
- R4: The pins {cs_n,ras_n,cas_n,we_n} only ever carry one of these codes: NOP 0111, activate 0011, read 0101, write 0100, precharge 0010, refresh 0001, mode write 0000.
- R5: No activate is issued sooner than T_MRD clocks after the mode write. If a request is already waiting, the activate comes exactly T_MRD clocks after it.
- R6: An activate carries the request bank on BA and the row on A. The read or write follows exactly T_RCD clocks later, to the same bank. Its A[7:0] holds the column, A10 is 1 and the other A bits are 0.
- R7: After a read, the next activate or refresh waits at least G_RD = max(T_RC-T_RCD, T_RAS+T_RP-T_RCD, 1+T_RP) clocks. It comes exactly then if work is waiting.
- R8: After a write, the next activate or refresh waits at least G_WR = max(T_RC-T_RCD, T_RAS+T_RP-T_RCD, T_DAL) clocks. It comes exactly then if work is waiting.
- R9: The refresh interval is REFI = floor(floor(64000000/4096)/CLK_NS) clocks. With no traffic, refreshes are exactly REFI apart. Under traffic, no gap exceeds REFI+T_RCD+G_WR.
- R10: When a refresh is pending and a request is waiting at the same idle decision, the refresh is issued first. The activate then follows exactly T_RFC clocks later.
- R11: No command follows a refresh sooner than T_RFC clocks.
- R12: req_ack is 1 only in the cycle the read or write is on the pins. Changes to the request inputs after the activate have no effect on the column command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all pins change after its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A transaction is requested |
| req_write | input | 1 | 1 for write, 0 for read |
| req_bank | input | BANK_W | Bank of the transaction |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| req_ack | output | 1 | Column command issued for the request this cycle |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank select |
| sd_addr | output | ROW_W | Multiplexed address; bit 10 is the auto-precharge / all-banks flag |
| sd_dqm | output | DQM_W | Byte masks |

## Verification
The checker assumes that the request inputs stay stable from the moment req_valid rises until req_ack. The one exception is the deliberate change after the activate that R12 covers. The checker also assumes that T_RCD and T_RFC are at least 1 and that REFI is well above the length of one transaction. The bench follows these rules. It raises each request only after the previous acknowledge, holds it until its own acknowledge, and uses a small timing set with REFI = 62. That set gives G_RD = 4 and G_WR = 6, so the two recovery paths can be told apart. The request sweep covers every bank, both directions, the lowest and highest row and column, and a mixed pattern. Refreshes fall between transactions and exercise the priority rule.

// File: rtl/sdram_seq_pkg.sv
`timescale 1ns/1ps
package sdram_seq_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MODE = 4'b0000,
        CMD_REF  = 4'b0001,
        CMD_PRE  = 4'b0010,
        CMD_ACT  = 4'b0011,
        CMD_WR   = 4'b0100,
        CMD_RD   = 4'b0101,
        CMD_NOP  = 4'b0111
    } sd_cmd_e;

    typedef enum logic [2:0] {
        ST_POWERUP,
        ST_INIT_REF1,
        ST_INIT_REF2,
        ST_INIT_MODE,
        ST_IDLE,
        ST_COLUMN
    } seq_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sdram_gap_timer.sv
`timescale 1ns/1ps
module sdram_gap_timer #(
    parameter int TW      = 8,
    parameter int RST_VAL = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          done
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= TW'(RST_VAL);
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/sdram_refresh_timer.sv
`timescale 1ns/1ps
module sdram_refresh_timer #(
    parameter int REFI = 1562
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    output logic pending
);
    localparam int RW = $clog2(REFI + 1);

    logic [RW-1:0] cnt;
    logic          tick;

    assign tick = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= RW'(REFI - 1);
            pending <= 1'b0;
        end else begin
            cnt <= tick ? RW'(REFI - 1) : cnt - 1'b1;
            if (tick)
                pending <= 1'b1;
            else if (clear)
                pending <= 1'b0;
        end
    end
endmodule

// File: rtl/sdram_seq.sv
`timescale 1ns/1ps
module sdram_seq
    import sdram_seq_pkg::*;
#(
    parameter int ROW_W         = 12,
    parameter int COL_W         = 8,
    parameter int BANK_W        = 2,
    parameter int DQM_W         = 2,
    parameter int CLK_NS        = 10,
    parameter int REF_WINDOW_NS = 64_000_000,
    parameter int REF_COUNT     = 4096,
    parameter int T_INIT        = 10000,
    parameter int T_RP          = 2,
    parameter int T_RFC         = 7,
    parameter int T_MRD         = 2,
    parameter int T_RCD         = 2,
    parameter int T_RAS         = 5,
    parameter int T_RC          = 7,
    parameter int T_DAL         = 4,
    parameter int CAS_LAT       = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    output logic              req_ack,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ROW_W-1:0]  sd_addr,
    output logic [DQM_W-1:0]  sd_dqm
);
    localparam int AP_BIT = 10;
    localparam int REFI   = REF_WINDOW_NS / REF_COUNT / CLK_NS;
    localparam int G_RD   = max3(T_RC - T_RCD, T_RAS + T_RP - T_RCD, 1 + T_RP);
    localparam int G_WR   = max3(T_RC - T_RCD, T_RAS + T_RP - T_RCD, T_DAL);
    localparam int TW     = $clog2(T_INIT + T_RFC + G_WR + G_RD + T_MRD + T_RCD + T_RP + 2);
    localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CAS_LAT << 4);

    seq_state_e        state, state_nx;
    sd_cmd_e           cmd_nx, cmd_q;
    logic [BANK_W-1:0] ba_nx;
    logic [ROW_W-1:0]  addr_nx;
    logic              ack_nx;
    logic              load;
    logic [TW-1:0]     load_val;
    logic              gap_done;
    logic              ref_pending, ref_clear;
    logic              take_req;
    logic              hold_write;
    logic [BANK_W-1:0] hold_bank;
    logic [COL_W-1:0]  hold_col;

    sdram_gap_timer #(.TW(TW), .RST_VAL(T_INIT - 1)) u_gap (
        .clk(clk), .rst(rst), .load(load), .load_val(load_val), .done(gap_done)
    );

    sdram_refresh_timer #(.REFI(REFI)) u_refi (
        .clk(clk), .rst(rst), .clear(ref_clear), .pending(ref_pending)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_POWERUP;
        else     state <= state_nx;
    end

    // next command and next state
    always_comb begin
        state_nx  = state;
        cmd_nx    = CMD_NOP;
        ba_nx     = '0;
        addr_nx   = '0;
        ack_nx    = 1'b0;
        load      = 1'b0;
        load_val  = '0;
        ref_clear = 1'b0;
        take_req  = 1'b0;
        unique case (state)
            ST_POWERUP: if (gap_done) begin
                cmd_nx           = CMD_PRE;
                addr_nx[AP_BIT]  = 1'b1;
                load             = 1'b1;
                load_val         = TW'(T_RP - 1);
                state_nx         = ST_INIT_REF1;
            end
            ST_INIT_REF1: if (gap_done) begin
                cmd_nx    = CMD_REF;
                ref_clear = 1'b1;
                load      = 1'b1;
                load_val  = TW'(T_RFC - 1);
                state_nx  = ST_INIT_REF2;
            end
            ST_INIT_REF2: if (gap_done) begin
                cmd_nx    = CMD_REF;
                ref_clear = 1'b1;
                load      = 1'b1;
                load_val  = TW'(T_RFC - 1);
                state_nx  = ST_INIT_MODE;
            end
            ST_INIT_MODE: if (gap_done) begin
                cmd_nx   = CMD_MODE;
                addr_nx  = MODE_WORD;
                load     = 1'b1;
                load_val = TW'(T_MRD - 1);
                state_nx = ST_IDLE;
            end
            ST_IDLE: if (gap_done) begin
                if (ref_pending) begin
                    cmd_nx    = CMD_REF;
                    ref_clear = 1'b1;
                    load      = 1'b1;
                    load_val  = TW'(T_RFC - 1);
                end else if (req_valid) begin
                    cmd_nx   = CMD_ACT;
                    ba_nx    = req_bank;
                    addr_nx  = req_row;
                    take_req = 1'b1;
                    load     = 1'b1;
                    load_val = TW'(T_RCD - 1);
                    state_nx = ST_COLUMN;
                end
            end
            ST_COLUMN: if (gap_done) begin
                cmd_nx          = hold_write ? CMD_WR : CMD_RD;
                ba_nx           = hold_bank;
                addr_nx         = ROW_W'(hold_col);
                addr_nx[AP_BIT] = 1'b1;
                ack_nx          = 1'b1;
                load            = 1'b1;
                load_val        = hold_write ? TW'(G_WR - 1) : TW'(G_RD - 1);
                state_nx        = ST_IDLE;
            end
            default: state_nx = ST_POWERUP;
        endcase
    end

    // request hold registers
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_write <= 1'b0;
            hold_bank  <= '0;
            hold_col   <= '0;
        end else if (take_req) begin
            hold_write <= req_write;
            hold_bank  <= req_bank;
            hold_col   <= req_col;
        end
    end

    // registered pin outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= CMD_NOP;
            sd_ba   <= '0;
            sd_addr <= '0;
            req_ack <= 1'b0;
            sd_dqm  <= '1;
        end else begin
            cmd_q   <= cmd_nx;
            sd_ba   <= ba_nx;
            sd_addr <= addr_nx;
            req_ack <= ack_nx;
            if (cmd_nx == CMD_MODE)
                sd_dqm <= '0;
        end
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
endmodule

// File: rtl/sdram_seq_chk.sv
`timescale 1ns/1ps
module sdram_seq_chk #(
    parameter int T_RCD = 2,
    parameter int T_RFC = 7,
    parameter int DQM_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             sd_cs_n,
    input logic             sd_ras_n,
    input logic             sd_cas_n,
    input logic             sd_we_n,
    input logic             ap_bit,
    input logic [DQM_W-1:0] sd_dqm,
    input logic             req_ack
);
    localparam logic [3:0] K_NOP = 4'b0111;
    localparam logic [3:0] K_ACT = 4'b0011;
    localparam logic [3:0] K_RD  = 4'b0101;
    localparam logic [3:0] K_WR  = 4'b0100;
    localparam logic [3:0] K_PRE = 4'b0010;
    localparam logic [3:0] K_REF = 4'b0001;
    localparam logic [3:0] K_MOD = 4'b0000;

    logic [3:0] cmd, lastc;
    int         g;
    logic       mode_seen;
    logic       legal, is_col;

    assign cmd    = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    assign is_col = (cmd == K_RD) || (cmd == K_WR);
    assign legal  = (cmd == K_NOP) || (cmd == K_ACT) || is_col || (cmd == K_PRE)
                 || (cmd == K_REF) || (cmd == K_MOD);

    always_ff @(posedge clk) begin
        if (rst) begin
            lastc     <= K_NOP;
            g         <= 0;
            mode_seen <= 1'b0;
        end else begin
            if (cmd != K_NOP) begin
                lastc <= cmd;
                g     <= 1;
            end else if (g < 1000000) begin
                g <= g + 1;
            end
            if (cmd == K_MOD)
                mode_seen <= 1'b1;
        end
    end

    p_cmd_legal_r4: assert property (@(posedge clk) disable iff (rst) legal);

    p_rcd_gap_r6: assert property (@(posedge clk) disable iff (rst)
        is_col |-> (lastc == K_ACT && g == T_RCD));

    p_ref_recover_r11: assert property (@(posedge clk) disable iff (rst)
        (cmd != K_NOP && lastc == K_REF) |-> (g >= T_RFC));

    p_ack_col_r12: assert property (@(posedge clk) disable iff (rst)
        req_ack |-> (is_col && ap_bit));

    p_dqm_boot_r3: assert property (@(posedge clk) disable iff (rst)
        (!mode_seen && cmd != K_MOD) |-> (sd_dqm == '1));

    p_dqm_run_r3: assert property (@(posedge clk) disable iff (rst)
        mode_seen |-> (sd_dqm == '0));
endmodule

bind sdram_seq sdram_seq_chk #(.T_RCD(T_RCD), .T_RFC(T_RFC), .DQM_W(DQM_W)) u_chk (
    .clk(clk), .rst(rst),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .ap_bit(sd_addr[10]), .sd_dqm(sd_dqm), .req_ack(req_ack)
);

// File: tb/tb_sdram_seq.sv
`timescale 1ns/1ps
module tb_sdram_seq;
    localparam int CLK_NS  = 250;
    localparam int T_INIT  = 20;
    localparam int T_RP    = 2;
    localparam int T_RFC   = 7;
    localparam int T_MRD   = 2;
    localparam int T_RCD   = 3;
    localparam int T_RAS   = 5;
    localparam int T_RC    = 7;
    localparam int T_DAL   = 6;
    localparam int CAS_LAT = 3;
    localparam int REFI    = (64000000 / 4096) / CLK_NS;
    localparam int A1      = T_RC - T_RCD;
    localparam int A2      = T_RAS + T_RP - T_RCD;
    localparam int G_RD    = (A1 > A2 ? A1 : A2) > 1 + T_RP ? (A1 > A2 ? A1 : A2) : 1 + T_RP;
    localparam int G_WR    = (A1 > A2 ? A1 : A2) > T_DAL ? (A1 > A2 ? A1 : A2) : T_DAL;

    localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                           C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001, C_MOD = 4'b0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_bank = '0;
    logic [11:0] req_row = '0;
    logic [7:0]  req_col = '0;
    logic        req_ack, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [11:0] sd_addr;
    logic [1:0]  sd_dqm;

    sdram_seq #(
        .CLK_NS(CLK_NS), .T_INIT(T_INIT), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD),
        .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RC(T_RC), .T_DAL(T_DAL), .CAS_LAT(CAS_LAT)
    ) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_ack(req_ack),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm)
    );

    always #2.5 clk = ~clk;

    int checks = 0, errors = 0;
    int cyc = 0;
    int prev_cyc = 0, last_ref = 0, ncmd = 0, idle_refs = 0;
    logic [3:0] prev_c = 4'b0111;
    bit   back2back = 1'b1, idle_mode = 1'b0;
    bit   exp_wr;
    int   exp_bank, exp_row, exp_col;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    function automatic logic [3:0] boot_cmd(input int i);
        case (i)
            0: return C_PRE;
            1, 2: return C_REF;
            default: return C_MOD;
        endcase
    endfunction

    // command monitor
    always @(negedge clk) begin
        logic [3:0] c;
        int gap, mn;
        if (!rst) begin
            c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            if (c != C_NOP) begin
                gap = cyc - prev_cyc;
                chk(c == C_ACT || c == C_RD || c == C_WR || c == C_PRE || c == C_REF || c == C_MOD,
                    "R4 command code", c, C_NOP);
                if (ncmd < 4) chk(c == boot_cmd(ncmd), "R2 start-up order", c, boot_cmd(ncmd));
                case (c)
                    C_PRE: begin
                        chk(sd_addr[10] == 1'b1, "R2 precharge-all A10", sd_addr[10], 1);
                        if (ncmd == 0) chk(cyc >= T_INIT, "R1 start-up wait", cyc, T_INIT);
                    end
                    C_REF: begin
                        if (prev_c == C_PRE) chk(gap == T_RP, "R2 precharge to refresh", gap, T_RP);
                        else if (prev_c == C_REF && ncmd == 2) chk(gap == T_RFC, "R2 refresh to refresh", gap, T_RFC);
                        else if (prev_c == C_REF) chk(gap >= T_RFC, "R11 refresh recovery", gap, T_RFC);
                        else if (prev_c == C_RD) begin
                            if (back2back) chk(gap == G_RD, "R10 refresh takes read slot", gap, G_RD);
                            else chk(gap >= G_RD, "R7 read recovery", gap, G_RD);
                        end else if (prev_c == C_WR) begin
                            if (back2back) chk(gap == G_WR, "R10 refresh takes write slot", gap, G_WR);
                            else chk(gap >= G_WR, "R8 write recovery", gap, G_WR);
                        end else if (prev_c == C_MOD) chk(gap >= T_MRD, "R5 mode recovery", gap, T_MRD);
                        if (ncmd >= 4) begin
                            if (idle_mode && idle_refs > 0)
                                chk(cyc - last_ref == REFI, "R9 idle refresh spacing", cyc - last_ref, REFI);
                            else
                                chk(cyc - last_ref <= REFI + T_RCD + G_WR, "R9 refresh spacing bound",
                                    cyc - last_ref, REFI + T_RCD + G_WR);
                            if (idle_mode) idle_refs++;
                        end
                        last_ref = cyc;
                    end
                    C_MOD: begin
                        chk(prev_c == C_REF && gap == T_RFC, "R2 refresh to mode write", gap, T_RFC);
                        chk(sd_addr == 12'(CAS_LAT << 4), "R3 mode word", sd_addr, CAS_LAT << 4);
                        chk(sd_ba == 2'd0, "R3 mode bank", sd_ba, 0);
                    end
                    C_ACT: begin
                        chk(sd_ba == exp_bank[1:0], "R6 activate bank", sd_ba, exp_bank);
                        chk(sd_addr == exp_row[11:0], "R6 activate row", sd_addr, exp_row);
                        mn = (prev_c == C_MOD) ? T_MRD : (prev_c == C_REF) ? T_RFC :
                             (prev_c == C_RD) ? G_RD : (prev_c == C_WR) ? G_WR : 0;
                        if (back2back) begin
                            if (prev_c == C_MOD) chk(gap == mn, "R5 first activate", gap, mn);
                            else if (prev_c == C_REF) chk(gap == mn, "R10 activate after refresh", gap, mn);
                            else if (prev_c == C_RD) chk(gap == mn, "R7 read to activate", gap, mn);
                            else chk(gap == mn, "R8 write to activate", gap, mn);
                        end else begin
                            chk(gap >= mn, "R7 R8 R11 activate spacing", gap, mn);
                        end
                    end
                    C_RD, C_WR: begin
                        chk(prev_c == C_ACT && gap == T_RCD, "R6 activate to column", gap, T_RCD);
                        chk(c == (exp_wr ? C_WR : C_RD), "R6 direction", c, exp_wr ? C_WR : C_RD);
                        chk(sd_ba == exp_bank[1:0], "R6 column bank", sd_ba, exp_bank);
                        chk(sd_addr == (12'h400 | 12'(exp_col)), "R6 column address",
                            sd_addr, 32'h400 | exp_col);
                        chk(req_ack == 1'b1, "R12 ack with column", req_ack, 1);
                        chk(sd_dqm == 2'b00, "R3 dqm in service", sd_dqm, 0);
                    end
                    default: ;
                endcase
                if (c != C_RD && c != C_WR) chk(req_ack == 1'b0, "R12 ack without column", req_ack, 0);
                prev_c   = c;
                prev_cyc = cyc;
                ncmd++;
            end else if (req_ack) begin
                chk(1'b0, "R12 ack on NOP", 1, 0);
            end
        end
    end

    task automatic do_req(input bit wr, input int b, input int r, input int cl, input bit scramble);
        #1;
        exp_wr = wr; exp_bank = b; exp_row = r; exp_col = cl;
        req_write = wr; req_bank = b[1:0]; req_row = r[11:0]; req_col = cl[7:0];
        req_valid = 1'b1;
        do begin
            @(negedge clk);
            if (scramble && {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_ACT) begin
                req_bank  = ~req_bank;
                req_col   = ~req_col;
                req_write = ~req_write;
            end
        end while (!req_ack);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R1 reset command",
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);
        chk(sd_dqm == 2'b11, "R1 reset dqm", sd_dqm, 3);
        chk(req_ack == 1'b0, "R1 reset ack", req_ack, 0);
        rst = 1'b0;
        back2back = 1'b1;
        for (int b = 0; b < 4; b++) begin
            for (int w = 0; w < 2; w++) begin
                for (int p = 0; p < 3; p++) begin
                    int r, cl;
                    r  = (p == 0) ? 0 : (p == 1) ? 4095 : (12'hA5A ^ b);
                    cl = (p == 0) ? 0 : (p == 1) ? 255 : (8'h5A + b);
                    do_req(w[0], b, r, cl, 1'b0);
                end
            end
        end
        do_req(1'b1, 2, 12'h123, 8'h3C, 1'b1);
        do_req(1'b0, 1, 12'h0F0, 8'hC3, 1'b1);
        back2back = 1'b0;
        repeat (8) @(negedge clk);
        idle_refs = 0;
        idle_mode = 1'b1;
        repeat (4 * REFI + 10) @(negedge clk);
        chk(idle_refs >= 3, "R9 idle refresh count", idle_refs, 3);
        idle_mode = 1'b0;
        do_req(1'b1, 3, 12'h777, 8'h11, 1'b0);
        repeat (10) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual %0d expected %0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule